// File: doc/BRIEF.md
# Main Memory Chip-Select Decoder

This block sits beside a bus target and decides, for each memory cycle, whether the address belongs to main memory behind the host bridge. If it does, the block raises a chip-select toward the host bridge. If it does not, the block raises an "unclaimed" flag so the cycle can be passed on to the expansion bus by subtractive decode. The chip-select never brings a device-select response with it.

The decision combines several programmable regions. A low region covers 0 to 512 KB. Fifteen attributed regions between 512 KB and 1 MB each have their own read and write enables. An extended region runs from 1 MB up to a limit set in 2 MB steps. A hole, set in 64 KB steps between 1 MB and 16 MB, overrides every positive hit inside it. Nothing at or above 512 MB is ever claimed.

Configuration arrives through a byte-wide register write port. The response path is a three-state machine with these states:
- `ST_IDLE`: no cycle.
- `ST_CLAIM`: chip-select asserted.
- `ST_PASS`: unclaimed flag asserted.

Each clock, the machine takes one of three transitions:
- `to_idle`: the strobe is low.
- `to_claim`: the strobe is high and the decode hits.
- `to_pass`: the strobe is high and the decode misses.

Top module: `memcs_decoder`

## Requirements
- R1: After reset all configuration fields are zero, both outputs are low, and a cycle to any address is reported unclaimed.
- R2: The outputs reflect the cycle presented one clock earlier. When the strobe was low, both outputs are low. When the strobe was high, exactly one of `memcs` and `unclaimed` is high.
- R3: An address at or above 512 MB (bits 31:29 not all zero) is never claimed, whatever the configuration.
- R4: Addresses 0 to 512 KB are claimed for both reads and writes when the low enable (register 4, bit 7) is set. This region has no read or write attributes.
- R5: Between 512 KB and 1 MB there are fifteen attributed segments, and a read there is claimed only if that segment's read-enable bit is set. The segment indices are:
  - index 0: 512–640 KB
  - index 1: 640–768 KB
  - indices 2 to 9: the eight 16 KB slices of 768–896 KB
  - indices 10 to 13: the four 16 KB slices of 896–960 KB
  - index 14: 960 KB–1 MB

  Read-enable bits 7:0 are in register 3, and bits 14:8 are in register 4, bits 6:0.
- R6: A write to an attributed segment is claimed only if that segment's write-enable bit is set, independently of its read enable. Write-enable bits 7:0 are in register 5, and bits 14:8 are in register 6, bits 6:0.
- R7: When the extended enable (register 6, bit 7) is set, addresses from 1 MB up to, but not including, (T+1)×2 MB are claimed for reads and writes, where T is register 0.
- R8: Register 1 (base B) and register 2 (size S) define a hole of 64 KB units [B, B+S), clipped to the span 1 MB to 16 MB. No address inside the clipped hole is claimed. The hole has no effect below 1 MB.
- R9: A register write takes effect for cycles presented from the next clock onward. A cycle presented in the same clock as a write is decoded with the previous settings.
- R10: A write to register address 7 changes no decode setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Memory cycle strobe |
| cyc_addr | input | 32 | Cycle byte address |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 8 | Register write data |
| memcs | output | 1 | Main-memory chip-select |
| unclaimed | output | 1 | Cycle not claimed, forward to expansion bus |

## Verification
A configuration write and a decoded cycle can land in the same clock. The bench provokes this by enabling the low region in the very clock that presents a read at address 0x1000. It expects that read to come back unclaimed, decoded with the old settings, and an identical read one clock later to be claimed. A second overlap is the hole coinciding with the extended region. The bench judges this at the hole's edges, at the 1 MB floor, and at the 16 MB clip.

// File: rtl/memcs_pkg.sv
package memcs_pkg;
    localparam int ADDR_W   = 32;
    localparam int CFG_DW   = 8;
    localparam int CFG_AW   = 3;
    localparam int SEG_N    = 15;
    localparam int TOP_W    = 8;
    localparam int HOLE_W   = 8;
    localparam int SEG_IW   = $clog2(SEG_N);

    localparam logic [CFG_AW-1:0] RA_TOP    = 3'd0;
    localparam logic [CFG_AW-1:0] RA_HBASE  = 3'd1;
    localparam logic [CFG_AW-1:0] RA_HSIZE  = 3'd2;
    localparam logic [CFG_AW-1:0] RA_RDLO   = 3'd3;
    localparam logic [CFG_AW-1:0] RA_RDHI   = 3'd4;
    localparam logic [CFG_AW-1:0] RA_WRLO   = 3'd5;
    localparam logic [CFG_AW-1:0] RA_WRHI   = 3'd6;

    typedef struct packed {
        logic              low_en;
        logic              ext_en;
        logic [TOP_W-1:0]  top;
        logic [HOLE_W-1:0] hole_base;
        logic [HOLE_W-1:0] hole_size;
        logic [SEG_N-1:0]  seg_rd;
        logic [SEG_N-1:0]  seg_wr;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_PASS  = 2'd2
    } st_t;
endpackage

// File: rtl/memcs_cfg_regs.sv
module memcs_cfg_regs
    import memcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output cfg_t              cfg
);
    logic [CFG_DW-1:0] r_top, r_hbase, r_hsize, r_rdlo, r_rdhi, r_wrlo, r_wrhi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_top   <= '0;
            r_hbase <= '0;
            r_hsize <= '0;
            r_rdlo  <= '0;
            r_rdhi  <= '0;
            r_wrlo  <= '0;
            r_wrhi  <= '0;
        end else if (we) begin
            unique case (addr)
                RA_TOP:   r_top   <= wdata;
                RA_HBASE: r_hbase <= wdata;
                RA_HSIZE: r_hsize <= wdata;
                RA_RDLO:  r_rdlo  <= wdata;
                RA_RDHI:  r_rdhi  <= wdata;
                RA_WRLO:  r_wrlo  <= wdata;
                RA_WRHI:  r_wrhi  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        cfg.top       = r_top;
        cfg.hole_base = r_hbase;
        cfg.hole_size = r_hsize;
        cfg.low_en    = r_rdhi[CFG_DW-1];
        cfg.ext_en    = r_wrhi[CFG_DW-1];
        cfg.seg_rd    = {r_rdhi[CFG_DW-2:0], r_rdlo};
        cfg.seg_wr    = {r_wrhi[CFG_DW-2:0], r_wrlo};
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg));
endmodule

// File: rtl/memcs_range_dec.sv
module memcs_range_dec
    import memcs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  cfg_t              cfg,
    output logic              hit
);
    logic              below_cap;
    logic              low_zone, legacy_zone, ext_zone;
    logic [SEG_IW-1:0] seg_idx;
    logic              seg_ok;
    logic              hole_span, hole_hit;
    logic [HOLE_W-1:0] unit64k;
    logic [HOLE_W:0]   hole_end;

    always_comb begin
        below_cap   = (addr[31:29] == 3'b000);
        low_zone    = below_cap && (addr[28:19] == '0);
        legacy_zone = below_cap && (addr[28:20] == '0) && addr[19];
        ext_zone    = below_cap && (addr[28:20] != '0) && (addr[28:21] <= cfg.top);
    end

    always_comb begin
        unique case (addr[18:17])
            2'd0: seg_idx = 4'd0;
            2'd1: seg_idx = 4'd1;
            2'd2: seg_idx = 4'd2 + {1'b0, addr[16:14]};
            default: seg_idx = addr[16] ? 4'd14 : (4'd10 + {2'b00, addr[15:14]});
        endcase
        seg_ok = is_write ? cfg.seg_wr[seg_idx] : cfg.seg_rd[seg_idx];
    end

    always_comb begin
        unit64k   = addr[23:16];
        hole_span = (addr[31:24] == '0) && (addr[23:20] != 4'd0);
        hole_end  = {1'b0, cfg.hole_base} + {1'b0, cfg.hole_size};
        hole_hit  = hole_span && (unit64k >= cfg.hole_base) && ({1'b0, unit64k} < hole_end);
    end

    always_comb begin
        hit = 1'b0;
        if (low_zone)
            hit = cfg.low_en;
        else if (legacy_zone)
            hit = seg_ok;
        else if (ext_zone)
            hit = cfg.ext_en && !hole_hit;
    end
endmodule

// File: rtl/memcs_resp_fsm.sv
module memcs_resp_fsm
    import memcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_valid,
    input  logic hit,
    output logic memcs,
    output logic unclaimed
);
    st_t state, state_nx;

    always_comb begin
        if (!cyc_valid)
            state_nx = ST_IDLE;
        else if (hit)
            state_nx = ST_CLAIM;
        else
            state_nx = ST_PASS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        memcs     = 1'b0;
        unclaimed = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_CLAIM: memcs = 1'b1;
            ST_PASS:  unclaimed = 1'b1;
            default:  ;
        endcase
    end

    // R2
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(memcs && unclaimed));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> (!memcs && !unclaimed));
    // R2
    answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> (memcs || unclaimed));
endmodule

// File: rtl/memcs_decoder.sv
module memcs_decoder
    import memcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [31:0]       cyc_addr,
    input  logic              cyc_write,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              memcs,
    output logic              unclaimed
);
    cfg_t cfg;
    logic hit;

    memcs_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    memcs_range_dec u_dec (
        .addr     (cyc_addr),
        .is_write (cyc_write),
        .cfg      (cfg),
        .hit      (hit)
    );

    memcs_resp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .hit       (hit),
        .memcs     (memcs),
        .unclaimed (unclaimed)
    );

    // R3
    high_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (cyc_addr[31:29] != 3'b000)) |=> !memcs);
endmodule

// File: tb/sim_memcs_decoder.sv
module sim_memcs_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_valid = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic       cyc_write = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       memcs, unclaimed;
    int         n_chk = 0;
    int         n_err = 0;

    always #4 clk = ~clk;

    memcs_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_write(cyc_write), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .memcs(memcs), .unclaimed(unclaimed)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {memcs,unclaimed} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic w, input logic exp_cs);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_addr = a; cyc_write = w;
        @(negedge clk);
        cyc_valid = 1'b0;
        check(req, {memcs, unclaimed}, {exp_cs, !exp_cs});
    endtask

    task automatic t_reset;
        check("R1 reset outputs", {memcs, unclaimed}, 2'b00);
        probe("R1 addr 0 after reset", 32'h0, 1'b0, 1'b0);
        probe("R1 ext after reset", 32'h0010_0000, 1'b1, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        cyc_valid = 1'b0; cyc_addr = 32'h0;
        @(negedge clk);
        check("R2 idle outputs", {memcs, unclaimed}, 2'b00);
    endtask

    task automatic t_ignored_reg;
        cfg_wr(3'd7, 8'hFF);
        probe("R10 reg7 low region", 32'h0000_1000, 1'b0, 1'b0);
        probe("R10 reg7 segment", 32'h000C_0000, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 8'h80;
        cyc_valid = 1'b1; cyc_addr = 32'h0000_1000; cyc_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; cyc_valid = 1'b0;
        check("R9 same-clock write uses old", {memcs, unclaimed}, 2'b01);
        probe("R9 next clock uses new", 32'h0000_1000, 1'b0, 1'b1);
    endtask

    task automatic t_low;
        probe("R4 low top write", 32'h0007_FFFF, 1'b1, 1'b1);
        probe("R4 low read", 32'h0000_0000, 1'b0, 1'b1);
        probe("R5 seg0 disabled", 32'h0008_0000, 1'b0, 1'b0);
    endtask

    task automatic t_segments;
        cfg_wr(3'd3, 8'h08);
        probe("R5 seg3 read", 32'h000C_4000, 1'b0, 1'b1);
        probe("R6 seg3 write off", 32'h000C_4000, 1'b1, 1'b0);
        probe("R5 seg2 read off", 32'h000C_0000, 1'b0, 1'b0);
        cfg_wr(3'd6, 8'h40);
        probe("R6 seg14 write", 32'h000F_8000, 1'b1, 1'b1);
        probe("R5 seg14 read off", 32'h000F_8000, 1'b0, 1'b0);
        cfg_wr(3'd4, 8'h84);
        probe("R5 seg10 read", 32'h000E_0000, 1'b0, 1'b1);
        probe("R5 seg11 read off", 32'h000E_4000, 1'b0, 1'b0);
    endtask

    task automatic t_extended;
        cfg_wr(3'd0, 8'h01);
        cfg_wr(3'd6, 8'hC0);
        probe("R7 1MB start", 32'h0010_0000, 1'b0, 1'b1);
        probe("R7 below limit", 32'h003F_FFFF, 1'b1, 1'b1);
        probe("R7 at limit", 32'h0040_0000, 1'b0, 1'b0);
        cfg_wr(3'd0, 8'hFF);
        probe("R7 top of 512MB", 32'h1FFF_FFFC, 1'b0, 1'b1);
        probe("R3 at 512MB", 32'h2000_0000, 1'b0, 1'b0);
        probe("R3 at 4GB-4", 32'hFFFF_FFFC, 1'b1, 1'b0);
    endtask

    task automatic t_hole;
        cfg_wr(3'd1, 8'h20);
        cfg_wr(3'd2, 8'h10);
        probe("R8 hole start", 32'h0020_0000, 1'b0, 1'b0);
        probe("R8 hole last", 32'h002F_FFFF, 1'b1, 1'b0);
        probe("R8 after hole", 32'h0030_0000, 1'b0, 1'b1);
        probe("R8 before hole", 32'h001F_FFFF, 1'b0, 1'b1);
        cfg_wr(3'd1, 8'hF8);
        cfg_wr(3'd2, 8'h20);
        probe("R8 clipped inside", 32'h00FF_0000, 1'b0, 1'b0);
        probe("R8 clipped at 16MB", 32'h0100_0000, 1'b0, 1'b1);
        cfg_wr(3'd1, 8'h00);
        cfg_wr(3'd2, 8'h20);
        probe("R8 no effect below 1MB", 32'h0000_0000, 1'b0, 1'b1);
        probe("R8 hole at 1MB", 32'h0010_0000, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_ignored_reg();
        t_same_cycle();
        t_low();
        t_segments();
        t_extended();
        t_hole();
        t_idle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule